// File: doc/BRIEF.md
# Block-Based Video Memory DMA Engine

This engine copies data from the system address space into the video memory window (8000h to 9FFFh). It works in units of 16-byte blocks. The CPU programs a source address, a destination address and a control byte through a small register port. The write to the control byte starts the copy. Each byte moves in three steps: a read request on a valid/ready channel, a read response, and a write on a second valid/ready channel.

There are two modes. The general-purpose mode copies every block back to back and holds the CPU stall output high until the last byte is written. The horizontal-blank mode copies one block on each rising edge of the horizontal-blank input, but only during visible lines. It stalls the CPU only while that block is in flight. Software can cancel a horizontal-blank transfer between blocks. The control register reads back the number of remaining blocks minus one, and bit 7 of the readback is set when the engine is idle.

Back-pressure rules: once `rd_valid` is high, it stays high and `rd_addr` stays stable until `rd_ready` is sampled high. Once `wr_valid` is high, it stays high and `wr_addr` and `wr_data` stay stable until `wr_ready` is sampled high. The engine always accepts a read response and ignores `rsp_valid` unless it is waiting for one. It keeps at most one request outstanding, and it never drives both valids at the same time.

Top module: `vram_block_dma`

## Requirements
- R1: After reset, the control readback (`reg_sel`=4) is FFh, `cpu_stall` is 0, and neither `rd_valid` nor `wr_valid` is asserted. Every other `reg_sel` value reads FFh.
- R2: Register selects are 0 = source high, 1 = source low, 2 = destination high, 3 = destination low. Bits 3:0 of both start addresses are forced to 0. Only bits 4:0 of the destination-high byte are kept, so every write address is 8000h plus a 13-bit offset.
- R3: A write to `reg_sel`=4 while idle starts a transfer. Data bits 6:0 give the block count minus one, and bit 7 gives the mode (0 = general purpose, 1 = horizontal blank). While active, the readback has bit 7 = 0 and bits 6:0 = remaining blocks minus one. While idle, no bus request is made.
- R4: In general-purpose mode, (N+1)x16 bytes are copied in ascending address order. `cpu_stall` stays high from the cycle after the start write until the final write handshake. After that, the readback is FFh.
- R5: In horizontal-blank mode, exactly one block moves per rising edge of `hblank` seen while `line` < 144. Edges seen while `line` >= 144 move nothing. `cpu_stall` is low between blocks.
- R6: Each completed block lowers readback bits 6:0 by one, in the same clock edge as the block's last write handshake.
- R7: A control write with bit 7 = 0 during an active horizontal-blank transfer, with no block in flight, stops it. The readback then shows bit 7 = 1 with bits 6:0 unchanged, and later `hblank` edges move nothing. A control write with bit 7 = 1 while active is ignored.
- R8: When a block's last byte lands at 9FFFh, the transfer ends there. The readback shows bit 7 = 1 and bits 6:0 decremented once for that block, and the destination offset wraps to 0.
- R9: The source and destination counters advance by one per written byte. They keep their values across blocks, completions and cancellations, so a new start without address writes continues from the next byte.
- R10: Each write carries exactly the byte returned by the read response for the current source address. Valids hold until their ready is sampled, and the two valids are never high together.
- R11: Writes to the address registers (`reg_sel` 0 to 3) are ignored while a transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 to 3 addresses, 4 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Control readback when `reg_sel`=4, otherwise FFh |
| hblank | input | 1 | Horizontal-blank level from the display side |
| line | input | 8 | Current display line number |
| cpu_stall | output | 1 | CPU hold request |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 16 | Read request address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 8 | Read response byte |
| wr_valid | output | 1 | Video memory write valid |
| wr_ready | input | 1 | Video memory write accepted |
| wr_addr | output | 16 | Video memory write address |
| wr_data | output | 8 | Video memory write byte |

## Verification
The bench checks the following corner cases, each against what a faulty design would do:

- Horizontal-blank edges during lines 144 and above. A design that ignored the line gate would copy a block there.
- A control write with bit 7 set while active. A design that restarted on it would reload the count.
- A cancel followed by a fresh start. A design that reset its address counters would reread the old source.
- A destination that reaches 9FFFh in mid transfer. A design without the overflow stop would wrap and keep writing at 8000h.
- Random read and write back-pressure with varying response latency, compared every clock against a reference model. This catches a design that drops or duplicates a byte, or that loses the stall between general-purpose blocks.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam logic [2:0] SEL_SRC_HI = 3'd0;
  localparam logic [2:0] SEL_SRC_LO = 3'd1;
  localparam logic [2:0] SEL_DST_HI = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_CTRL   = 3'd4;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_RD   = 2'd1,
    MV_RSP  = 2'd2,
    MV_WR   = 2'd3
  } mover_st_t;
endpackage

// File: rtl/vdma_addr_gen.sv
module vdma_addr_gen
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DST_W  = 13,
  parameter int BLK_LG = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              lock,
  input  logic              step,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dst_wrap
);
  localparam int PAD_W = ADDR_W - DST_W;

  logic [ADDR_W-1:0] src_q;
  logic [DST_W-1:0]  dst_q;
  logic              wr_ok;

  assign wr_ok = wr_en && !lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (step) begin
      src_q <= src_q + 1'b1;
      dst_q <= dst_q + 1'b1;
    end else if (wr_ok) begin
      case (wr_sel)
        SEL_SRC_HI: src_q[ADDR_W-1:8] <= wr_data[ADDR_W-9:0];
        SEL_SRC_LO: begin
          src_q[7:BLK_LG]   <= wr_data[7:BLK_LG];
          src_q[BLK_LG-1:0] <= '0;
        end
        SEL_DST_HI: dst_q[DST_W-1:8] <= wr_data[DST_W-9:0];
        SEL_DST_LO: begin
          dst_q[7:BLK_LG]   <= wr_data[7:BLK_LG];
          dst_q[BLK_LG-1:0] <= '0;
        end
        default: ;
      endcase
    end
  end

  assign src_addr = src_q;
  assign dst_addr = WIN_BASE | {{PAD_W{1'b0}}, dst_q};
  assign dst_wrap = step && (&dst_q);
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl #(
  parameter int LEN_W         = 7,
  parameter int LINE_W        = 8,
  parameter int VISIBLE_LINES = 144
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [LEN_W:0]   ctrl_data,
  input  logic             hblank,
  input  logic [LINE_W-1:0] line,
  input  logic             block_done,
  input  logic             dst_wrap,
  output logic             active,
  output logic             busy,
  output logic [LEN_W:0]   status,
  output logic             cpu_stall
);
  logic             mode_hb;
  logic             hb_q;
  logic [LEN_W-1:0] remain;
  logic             hb_edge;
  logic             cancel;
  logic             start;

  assign hb_edge = hblank && !hb_q && (line < LINE_W'(VISIBLE_LINES));
  assign start   = ctrl_wr && !active;
  assign cancel  = ctrl_wr && active && mode_hb && !ctrl_data[LEN_W] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      mode_hb <= 1'b0;
      busy    <= 1'b0;
      hb_q    <= 1'b0;
      remain  <= '1;
    end else begin
      hb_q <= hblank;
      if (block_done) begin
        remain <= remain - 1'b1;
        if (remain == '0 || dst_wrap) begin
          active <= 1'b0;
          busy   <= 1'b0;
        end else if (mode_hb) begin
          busy <= 1'b0;
        end
      end else if (active && !busy && !cancel && (!mode_hb || hb_edge)) begin
        busy <= 1'b1;
      end
      if (start) begin
        active  <= 1'b1;
        mode_hb <= ctrl_data[LEN_W];
        remain  <= ctrl_data[LEN_W-1:0];
      end else if (cancel) begin
        active <= 1'b0;
      end
    end
  end

  assign status    = {!active, remain};
  assign cpu_stall = busy || (active && !mode_hb);
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_LG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              byte_done,
  output logic              block_done
);
  mover_st_t         st;
  logic [BLK_LG-1:0] idx;
  logic [7:0]        data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= MV_IDLE;
      idx    <= '0;
      data_q <= '0;
    end else begin
      case (st)
        MV_IDLE: if (run) st <= MV_RD;
        MV_RD:   if (rd_ready) st <= MV_RSP;
        MV_RSP:  if (rsp_valid) begin
          data_q <= rsp_data;
          st     <= MV_WR;
        end
        MV_WR:   if (wr_ready) begin
          idx <= idx + 1'b1;
          st  <= (&idx) ? MV_IDLE : MV_RD;
        end
        default: st <= MV_IDLE;
      endcase
    end
  end

  assign rd_valid   = (st == MV_RD);
  assign rd_addr    = src_addr;
  assign wr_valid   = (st == MV_WR);
  assign wr_addr    = dst_addr;
  assign wr_data    = data_q;
  assign byte_done  = wr_valid && wr_ready;
  assign block_done = byte_done && (&idx);
endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
  import vdma_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DST_W         = 13,
  parameter int BLK_LG        = 4,
  parameter int LEN_W         = 7,
  parameter int LINE_W        = 8,
  parameter int VISIBLE_LINES = 144,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              hblank,
  input  logic [LINE_W-1:0] line,
  output logic              cpu_stall,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic              active;
  logic              busy;
  logic [LEN_W:0]    status;
  logic              byte_done;
  logic              block_done;
  logic              dst_wrap;
  logic [ADDR_W-1:0] src_addr;
  logic [ADDR_W-1:0] dst_addr;
  logic              ctrl_wr;

  assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);

  vdma_addr_gen #(
    .ADDR_W(ADDR_W), .DST_W(DST_W), .BLK_LG(BLK_LG), .WIN_BASE(WIN_BASE)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .lock(active), .step(byte_done),
    .src_addr(src_addr), .dst_addr(dst_addr), .dst_wrap(dst_wrap)
  );

  vdma_ctrl #(
    .LEN_W(LEN_W), .LINE_W(LINE_W), .VISIBLE_LINES(VISIBLE_LINES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(reg_wdata[LEN_W:0]),
    .hblank(hblank), .line(line), .block_done(block_done), .dst_wrap(dst_wrap),
    .active(active), .busy(busy), .status(status), .cpu_stall(cpu_stall)
  );

  vdma_mover #(
    .ADDR_W(ADDR_W), .BLK_LG(BLK_LG)
  ) u_mover (
    .clk(clk), .rst_n(rst_n), .run(busy), .src_addr(src_addr), .dst_addr(dst_addr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .byte_done(byte_done), .block_done(block_done)
  );

  assign reg_rdata = (reg_sel == SEL_CTRL) ? status : 8'hFF;
endmodule

// File: rtl/vdma_checks.sv
module vdma_checks #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              cpu_stall,
  input logic [7:0]        status
);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));

  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[15:13] == 3'b100));

  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> (!rd_valid && !wr_valid));

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_valid) |-> cpu_stall);
endmodule

bind vram_block_dma vdma_checks #(.ADDR_W(ADDR_W)) u_vdma_checks (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_addr(rd_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .cpu_stall(cpu_stall), .status(status)
);

// File: tb/tb_vram_block_dma.sv
module tb_vram_block_dma;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd4;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        hblank = 1'b0;
  logic [7:0]  line = 8'd0;
  logic        cpu_stall;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [15:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  vram_block_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank(hblank), .line(line),
    .cpu_stall(cpu_stall), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] memf(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory side: random back-pressure and response latency
  bit pend = 1'b0;
  int pend_wait = 0;
  logic [15:0] pend_addr = '0;
  always @(negedge clk) begin
    rsp_valid <= 1'b0;
    if (pend) begin
      if (pend_wait == 0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= memf(pend_addr);
        pend = 1'b0;
      end else begin
        pend_wait--;
      end
    end
    wr_ready <= (($urandom % 3) != 0);
    if (!pend && rd_valid && (($urandom % 4) != 0)) begin
      rd_ready <= 1'b1;
      pend = 1'b1;
      pend_wait = $urandom % 3;
      pend_addr = rd_addr;
    end else begin
      rd_ready <= 1'b0;
    end
  end

  // Reference model
  logic [15:0] m_src;
  logic [12:0] m_dst;
  logic [6:0]  m_rem;
  bit m_active, m_hb, m_busy, m_hbprev;
  int m_cnt;
  int wr_total = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = '0; m_dst = '0; m_rem = 7'h7F;
      m_active = 0; m_hb = 0; m_busy = 0; m_hbprev = 0; m_cnt = 0;
    end else begin
      bit edge_ok, cancel, done, ovf, o_active, o_busy;
      edge_ok  = hblank && !m_hbprev && (line < 8'd144);
      m_hbprev = hblank;
      o_active = m_active;
      o_busy   = m_busy;
      cancel   = reg_wr && reg_sel == 3'd4 && o_active && m_hb && !reg_wdata[7] && !o_busy;
      done = 0; ovf = 0;
      if (rd_valid && rd_ready)
        check("R9 read address", rd_addr, m_src);
      if (wr_valid && wr_ready) begin
        check("R2 write address", wr_addr, {3'b100, m_dst});
        check("R10 write data", wr_data, memf(m_src));
        wr_total++;
        ovf = (m_dst == 13'h1FFF);
        m_src++; m_dst++;
        m_cnt++;
        if (m_cnt == 16) begin m_cnt = 0; done = 1; end
      end
      if (done) begin
        if (m_rem == 0 || ovf) begin m_active = 0; m_busy = 0; end
        else if (m_hb) m_busy = 0;
        m_rem = m_rem - 1;
      end else if (o_active && !o_busy && !cancel && (!m_hb || edge_ok)) begin
        m_busy = 1;
      end
      if (reg_wr) begin
        if (reg_sel == 3'd4) begin
          if (!o_active) begin
            m_active = 1; m_hb = reg_wdata[7]; m_rem = reg_wdata[6:0];
          end else if (cancel) m_active = 0;
        end else if (!o_active) begin
          case (reg_sel)
            3'd0: m_src[15:8] = reg_wdata;
            3'd1: m_src[7:0]  = {reg_wdata[7:4], 4'h0};
            3'd2: m_dst[12:8] = reg_wdata[4:0];
            3'd3: m_dst[7:0]  = {reg_wdata[7:4], 4'h0};
            default: ;
          endcase
        end
      end
    end
  end

  // Every-clock comparison of readback and stall
  always @(posedge clk) begin
    #2;
    if (rst_n && reg_sel == 3'd4) begin
      check("R3 R6 readback", reg_rdata, {!m_active, m_rem});
      check("R4 R5 stall", cpu_stall, m_busy || (m_active && !m_hb));
    end
  end

  task automatic regw(logic [2:0] sel, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 3'd4;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!reg_rdata[7]) @(negedge clk);
  endtask

  task automatic hpulse(logic [7:0] ln);
    @(negedge clk);
    line = ln; hblank = 1'b1;
    repeat (3) @(negedge clk);
    hblank = 1'b0;
    repeat (2) @(negedge clk);
    while (cpu_stall) @(negedge clk);
  endtask

  task automatic first_read(string tag, logic [15:0] exp);
    @(posedge clk);
    while (!(rd_valid && rd_ready)) @(posedge clk);
    check(tag, rd_addr, exp);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 readback", reg_rdata, 8'hFF);
    check("R1 stall", cpu_stall, 1'b0);
    check("R1 idle bus", {rd_valid, wr_valid}, 2'b00);
    reg_sel = 3'd0; #1;
    check("R1 other select", reg_rdata, 8'hFF);
    reg_sel = 3'd4;

    // R2 R4: general purpose, 3 blocks
    regw(3'd0, 8'h12); regw(3'd1, 8'h34);
    regw(3'd2, 8'hE1); regw(3'd3, 8'h27);
    base = wr_total;
    regw(3'd4, 8'h02);
    check("R3 active readback", reg_rdata, 8'h02);
    first_read("R2 source masked", 16'h1230);
    wait_idle();
    check("R4 bytes copied", wr_total - base, 48);
    check("R4 done readback", reg_rdata, 8'hFF);

    // R5 R6: horizontal blank, 2 blocks
    base = wr_total;
    regw(3'd4, 8'h81);
    hpulse(8'd150);
    check("R5 no copy in lines 144+", wr_total - base, 0);
    check("R5 readback unchanged", reg_rdata, 8'h01);
    hpulse(8'd10);
    check("R5 one block per edge", wr_total - base, 16);
    check("R6 countdown", reg_rdata, 8'h00);
    check("R5 stall low between blocks", cpu_stall, 1'b0);
    hpulse(8'd11);
    check("R5 second block", wr_total - base, 32);
    check("R6 final readback", reg_rdata, 8'hFF);

    // R7 R11: cancel
    base = wr_total;
    regw(3'd4, 8'h85);
    hpulse(8'd5);
    check("R6 after first block", reg_rdata, 8'h04);
    regw(3'd4, 8'h81);
    check("R7 restart ignored", reg_rdata, 8'h04);
    regw(3'd0, 8'h00);
    regw(3'd4, 8'h00);
    check("R7 cancelled readback", reg_rdata, 8'h84);
    hpulse(8'd6);
    check("R7 no copy after cancel", wr_total - base, 16);
    check("R7 readback kept", reg_rdata, 8'h84);

    // R9 R11: counters continue
    base = wr_total;
    regw(3'd4, 8'h00);
    first_read("R9 R11 source continues", 16'h1290);
    wait_idle();
    check("R9 one block", wr_total - base, 16);
    check("R9 readback", reg_rdata, 8'hFF);

    // R8: destination overflow
    regw(3'd0, 8'h40); regw(3'd1, 8'h00);
    regw(3'd2, 8'h1F); regw(3'd3, 8'hE0);
    base = wr_total;
    regw(3'd4, 8'h05);
    wait_idle();
    check("R8 bytes before stop", wr_total - base, 32);
    check("R8 stop readback", reg_rdata, 8'h83);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule